// File: doc/BRIEF.md
# Timing-Error Pipeline Recovery Controller

This block is a four-stage datapath. Its stages are fetch, decode, execute and memory, and each stage ends in a self-checking register. Every checking register takes two samples of its input. The main flip-flop samples on the system clock. A capture element samples on a delayed copy of that clock, so it sees data that arrived late. If the two samples differ in any stage, one global mismatch is raised, and the controller spends exactly one clock edge on recovery. At that edge every main flip-flop reloads its captured value and nothing advances. The stage that saw the late data then runs again with correct inputs, and the stages behind it repeat their cycle. The pipeline is not flushed.

The first stage takes a new input word only when `in_ready` is high. The output `out_data` is the memory stage's function applied to the last checking register. The logic between registers is a simple parameterized function per stage. The `inj` vector is for test only. It makes one or more main flip-flops store the inverse of their input, which creates a timing error on demand. The controller has two states. `ST_RUN` is normal flow. `ST_REPLAY` is the one cycle after a recovery edge. The transition RUN→REPLAY is taken on any pending mismatch. REPLAY→RUN is always taken. REPLAY→REPLAY is never expected.

Top module: `tep_pipe`

## Requirements
- R1: While reset is held, all registers are zero, `error_o` is 0, `in_ready` is 1 and `out_data` equals f3(0).
- R2: The stage functions are f_k(x) = (x rotated left by k+1 bits) XOR (0x1D3·(k+1) truncated to W bits), for k = 0..3. Without errors, a word accepted at one edge appears on `out_data` as f3(f2(f1(f0(x)))) after the fourth edge, counting the accepting edge as the first.
- R3: If `inj[k]` is high at a clock edge in run mode, register k stores the bitwise inverse of its input and the capture element keeps the true value. The resulting mismatch drives `in_ready` low after the delayed clock edge.
- R4: `error_o` (registered) is high for exactly the one cycle that follows a recovery edge, and is low otherwise.
- R5: At a recovery edge every main register loads its captured value and no stage advances. `out_data` in the next cycle reflects the corrected contents.
- R6: `in_ready` is low exactly while a mismatch is pending. A word presented while it is low is not taken and must be held.
- R7: `inj` has no effect at a recovery edge. No mismatch and no second recovery follow from it.
- R8: Injections into several stages at the same edge cost one recovery cycle in total.
- R9: The stream of final output values equals the error-free stream exactly. Each effective error adds exactly one cycle, and back-to-back errors two edges apart are each recovered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; main flip-flops and controller |
| cap_clk | input | 1 | Delayed copy of clk; clocks the capture elements |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | W | Word presented to the fetch stage |
| inj | input | NST | Test-only per-stage timing-error injection |
| in_ready | output | 1 | High when the fetch stage takes `in_data` at the next edge |
| out_data | output | W | Memory-stage function of the last checking register |
| error_o | output | 1 | Registered global error; high during the replay cycle |

## Verification
The hardest situation to reach is an injection that lands on the recovery edge itself, where it must be ignored. A second hard case is a real error in the cycle right after the replay cycle. Neither happens by chance. The bench schedules injections on fixed cycle numbers, including one pair on adjacent edges and one pair two edges apart. It also fires all four stages at once. A behavioural model, driven by the same schedule, predicts every cycle. The filtered output stream is finally compared against the pure function chain of the input words.

// File: rtl/tep_pkg.sv
package tep_pkg;

    // Controller states: normal flow, and the single cycle after a recovery edge
    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_REPLAY = 1'b1
    } rec_state_e;

    // Base of the per-stage XOR constant (scaled by stage number + 1)
    localparam int unsigned KEY_BASE = 32'h0000_01D3;

endpackage

// File: rtl/tep_stage_fn.sv
module tep_stage_fn #(
    parameter int W   = 16,
    parameter int IDX = 0
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    localparam int          SH  = (IDX + 1) % W;
    localparam logic [W-1:0] KEY = W'(tep_pkg::KEY_BASE * (IDX + 1));

    logic [2*W-1:0] dbl;

    always_comb begin
        dbl = {x, x} << SH;
        y   = dbl[2*W-1 -: W] ^ KEY;
    end
endmodule

// File: rtl/tep_chk_reg.sv
module tep_chk_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         cap_clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         inj,
    input  logic         replay,
    output logic [W-1:0] q,
    output logic [W-1:0] cap_q,
    output logic         mism
);
    // hold_q keeps the settled input seen at the clock edge, so that the
    // delayed-clock capture sees the same datum under zero-delay timing
    logic [W-1:0] main_q;
    logic [W-1:0] hold_q;
    logic [W-1:0] capt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            hold_q <= '0;
        end else if (replay) begin
            main_q <= capt_q;
        end else begin
            main_q <= inj ? ~d : d;
            hold_q <= d;
        end
    end

    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) capt_q <= '0;
        else        capt_q <= hold_q;
    end

    assign q     = main_q;
    assign cap_q = capt_q;
    assign mism  = |(main_q ^ capt_q);
endmodule

// File: rtl/tep_recovery_ctrl.sv
module tep_recovery_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mis_any,
    output logic replay,
    output logic in_ready,
    output logic error_o
);
    import tep_pkg::*;

    rec_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    state_d = mis_any ? ST_REPLAY : ST_RUN;
            ST_REPLAY: state_d = mis_any ? ST_REPLAY : ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        replay   = mis_any;
        in_ready = !mis_any;
        error_o  = (state_q == ST_REPLAY);
    end
endmodule

// File: rtl/tep_pipe.sv
module tep_pipe #(
    parameter int W   = 16,
    parameter int NST = 4
) (
    input  logic           clk,
    input  logic           cap_clk,
    input  logic           rst_n,
    input  logic [W-1:0]   in_data,
    input  logic [NST-1:0] inj,
    output logic           in_ready,
    output logic [W-1:0]   out_data,
    output logic           error_o
);
    localparam int FLAT = NST * W;

    logic [W-1:0]   d_arr   [NST];
    logic [W-1:0]   q_arr   [NST];
    logic [W-1:0]   cap_arr [NST];
    logic [W-1:0]   fn_arr  [NST];
    logic [NST-1:0] mism_vec;
    logic [FLAT-1:0] main_flat;
    logic [FLAT-1:0] cap_flat;
    logic           mis_any;
    logic           replay;

    genvar k;
    generate
        for (k = 0; k < NST; k++) begin : g_stage
            if (k == 0) begin : g_first
                assign d_arr[k] = in_data;
            end else begin : g_rest
                assign d_arr[k] = fn_arr[k-1];
            end

            tep_chk_reg #(.W(W)) u_reg (
                .clk    (clk),
                .cap_clk(cap_clk),
                .rst_n  (rst_n),
                .d      (d_arr[k]),
                .inj    (inj[k]),
                .replay (replay),
                .q      (q_arr[k]),
                .cap_q  (cap_arr[k]),
                .mism   (mism_vec[k])
            );

            tep_stage_fn #(.W(W), .IDX(k)) u_fn (
                .x(q_arr[k]),
                .y(fn_arr[k])
            );

            assign main_flat[k*W +: W] = q_arr[k];
            assign cap_flat[k*W +: W]  = cap_arr[k];
        end
    endgenerate

    assign mis_any  = |mism_vec;
    assign out_data = fn_arr[NST-1];

    tep_recovery_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mis_any (mis_any),
        .replay  (replay),
        .in_ready(in_ready),
        .error_o (error_o)
    );
endmodule

// File: rtl/tep_pipe_chk.sv
module tep_pipe_chk #(
    parameter int W   = 16,
    parameter int NST = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             error_o,
    input logic [NST-1:0]   inj,
    input logic [NST*W-1:0] main_flat,
    input logic [NST*W-1:0] cap_flat
);
    // R3
    inj_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && (inj != '0)) |=> !in_ready);

    // R4
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> !error_o);

    // R4
    mis_to_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> error_o);

    // R5
    reload_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (main_flat == $past(cap_flat)));

    // R7
    replay_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> in_ready);
endmodule

bind tep_pipe tep_pipe_chk #(.W(W), .NST(NST)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .error_o  (error_o),
    .inj      (inj),
    .main_flat(main_flat),
    .cap_flat (cap_flat)
);

// File: tb/tep_pipe_bench.sv
module tep_pipe_bench;
    localparam int W      = 16;
    localparam int NST    = 4;
    localparam int NITEMS = 30;
    localparam int NCYC   = 48;

    logic           clk = 1'b0;
    logic           cap_clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   in_data = '0;
    logic [NST-1:0] inj = '0;
    logic           in_ready;
    logic [W-1:0]   out_data;
    logic           error_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tep_pipe #(.W(W), .NST(NST)) u_tep_pipe (
        .clk(clk), .cap_clk(cap_clk), .rst_n(rst_n), .in_data(in_data),
        .inj(inj), .in_ready(in_ready), .out_data(out_data), .error_o(error_o)
    );

    always #2 clk = ~clk;
    initial begin
        #3;
        cap_clk = 1'b1;
        forever #2 cap_clk = ~cap_clk;
    end

    function automatic logic [W-1:0] fk(input logic [W-1:0] x, input int k);
        logic [2*W-1:0] t;
        t  = {x, x} << (k + 1);
        fk = t[2*W-1 -: W] ^ W'(32'h1D3 * (k + 1));
    endfunction

    function automatic logic [W-1:0] itm(input int n);
        itm = W'(n * 32'h3B1) ^ 16'h5A5A;
    endfunction

    function automatic logic [NST-1:0] sched(input int c);
        case (c)
            6:       sched = 4'b0001;
            10:      sched = 4'b1000;
            14:      sched = 4'b0110;
            18:      sched = 4'b0100;
            19:      sched = 4'b0010;
            24:      sched = 4'b1111;
            26:      sched = 4'b1000;
            default: sched = 4'b0000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    logic [W-1:0] mr [NST];
    logic [W-1:0] mc [NST];
    logic [W-1:0] nd [NST];
    logic         merr;
    logic [W-1:0] got [$];
    logic [W-1:0] prev_out;
    bit           have_prev;

    initial begin
        int idx = 0;
        int neff = 0;
        int nerr_seen = 0;
        int nlow_seen = 0;
        bit mis, applied, ignored, multi, exp_ready;
        logic [W-1:0] g;

        repeat (2) @(negedge clk);
        chk("R1 out_data", out_data, fk('0, 3));
        chk("R1 in_ready", W'(in_ready), W'(1));
        chk("R1 error_o", W'(error_o), W'(0));
        for (int k = 0; k < NST; k++) begin
            mr[k] = '0;
            mc[k] = '0;
        end
        merr = 1'b0;
        have_prev = 1'b0;
        rst_n = 1'b1;

        for (int c = 0; c < NCYC; c++) begin
            in_data = itm(idx);
            inj     = sched(c);
            @(posedge clk);
            mis = 1'b0;
            for (int k = 0; k < NST; k++) if (mr[k] != mc[k]) mis = 1'b1;
            applied = !mis && (inj != '0);
            ignored = mis && (inj != '0);
            multi   = applied && ($countones(inj) > 1);
            if (mis) begin
                for (int k = 0; k < NST; k++) mr[k] = mc[k];
                merr = 1'b1;
            end else begin
                for (int k = 0; k < NST; k++)
                    nd[k] = (k == 0) ? in_data : fk(mr[k-1], k - 1);
                for (int k = 0; k < NST; k++) begin
                    mr[k] = inj[k] ? ~nd[k] : nd[k];
                    mc[k] = nd[k];
                end
                merr = 1'b0;
                idx++;
                if (applied) neff++;
            end
            @(negedge clk);
            exp_ready = 1'b1;
            for (int k = 0; k < NST; k++) if (mr[k] != mc[k]) exp_ready = 1'b0;
            chk(multi ? "R8 in_ready" : (applied ? "R3 in_ready" : "R6 in_ready"),
                W'(in_ready), W'(exp_ready));
            chk(ignored ? "R7 error_o" : "R4 error_o", W'(error_o), W'(merr));
            chk(merr ? "R5 out_data" : "R2 out_data", out_data, fk(mr[NST-1], NST - 1));
            if (error_o) nerr_seen++;
            if (!in_ready) nlow_seen++;
            if (have_prev && !error_o) got.push_back(prev_out);
            prev_out  = out_data;
            have_prev = 1'b1;
        end

        chk("R9 error cycles", W'(nerr_seen), W'(neff));
        chk("R9 stall cycles", W'(nlow_seen), W'(neff));
        chk("R9 stream length ok", W'(got.size() >= 3 + NITEMS), W'(1));
        for (int i = 0; i < 3 + NITEMS && i < got.size(); i++) begin
            if (i == 0)      g = fk(fk('0, 2), 3);
            else if (i == 1) g = fk(fk(fk('0, 1), 2), 3);
            else if (i == 2) g = fk(fk(fk(fk('0, 0), 1), 2), 3);
            else             g = fk(fk(fk(fk(itm(i - 3), 0), 1), 2), 3);
            chk("R9 stream", got[i], g);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule